// File: doc/BRIEF.md
# Multi-Domain Clock Enable Generator

This block runs entirely on one fast base clock. From it, the block derives a set of single-cycle enable strobes, one for each logical clock domain of a small microcontroller-style system. The domains are:

- a system domain at the full base rate;
- a core domain;
- a copy of the core domain that lags it;
- three peripheral domains, each with its own programmable divider;
- three auxiliary peripheral domains that tick whenever the primary peripheral divider reaches its terminal count.

Logic in each domain stays on the base clock and advances only on its strobe.

A 16-bit disable mask turns each domain off. Each domain has its own bit in the mask. A self-test mode applies an extra divider to the core pair. A ratio guard enforces one rule: the second peripheral domain must run at an integer multiple of the primary peripheral frequency. When the programmed fields break this rule, the guard latches an error flag and makes the second peripheral domain follow the primary ratio.

Every divider samples its ratio and its disable bit only when it reaches its terminal count. As a result, a period that is already running always completes at its programmed length.

Top module: `clk_en_gen`

## Requirements
- R1: While reset is asserted, every strobe and the error flag are low. On the first cycle after the first clock edge that samples reset released, all strobes pulse together, except the lagging core strobe. The error flag then shows the ratio check of the held fields.
- R2: A peripheral divide field of value v makes that strobe high for one cycle every v+1 cycles. The first pulse is at cycle 0 after reset, so pulses fall on cycles that are multiples of v+1.
- R3: A divider samples its ratio field and its disable bit on the cycle it pulses. The samples apply to the period that starts there. A change made mid-period never shortens or stretches the period that is running.
- R4: Disable bit positions are: 0 core, 1 system, 2 primary peripheral, 3 second peripheral, 8 third peripheral, 4 auxiliary 1, 5 auxiliary 2, 10 auxiliary 3. A set bit suppresses every pulse of its domain after the next terminal count, and leaves the other domains unchanged.
- R5: The lagging core strobe equals the core strobe delayed by exactly two base cycles. It therefore shares the core's disable bit and the core's self-test division.
- R6: With self-test low, the core strobe pulses every cycle. With self-test high and a self-test field t, the core strobe pulses once every t+1 cycles.
- R7: Each auxiliary strobe pulses on every terminal count of the primary peripheral divider, gated only by its own disable bit. It ignores bit 2, and it runs at the base rate when the primary field is 0.
- R8: When (primary field + 1) is not a multiple of (second field + 1), the error flag rises one edge later and stays high until reset. While the rule is broken, the second peripheral divider uses the primary field.
- R9: The system strobe pulses every cycle unless bit 1 is set. The core strobe does not depend on bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dis_mask_i | input | 16 | Per-domain disable bits |
| per1_div_i | input | 4 | Primary peripheral ratio minus one |
| per2_div_i | input | 4 | Second peripheral ratio minus one |
| per3_div_i | input | 4 | Third peripheral ratio minus one |
| selftest_i | input | 1 | Applies the self-test divider to the core pair |
| selftest_div_i | input | 3 | Self-test ratio minus one |
| sys_en_o | output | 1 | System domain strobe |
| core_en_o | output | 1 | Core domain strobe |
| core_lag_en_o | output | 1 | Lagging core strobe |
| per1_en_o | output | 1 | Primary peripheral strobe |
| per2_en_o | output | 1 | Second peripheral strobe |
| per3_en_o | output | 1 | Third peripheral strobe |
| asy1_en_o | output | 1 | Auxiliary strobe 1 |
| asy2_en_o | output | 1 | Auxiliary strobe 2 |
| asy3_en_o | output | 1 | Auxiliary strobe 3 |
| ratio_err_o | output | 1 | Sticky ratio-rule error |

## Verification
Every strobe is decoded combinationally from registers. The bench numbers cycles from 0, where cycle 0 is the cycle after the first edge that sees reset released. It expects:

- a divide-by-N strobe on each cycle that is a multiple of N;
- the lagging strobe exactly two cycles after the core strobe;
- the error flag from cycle 0;
- a mid-period field or mask change only after the pulse that ends the running period.

Inputs change and outputs are sampled on the falling edge, half a period away from the edge that updates the registers. Each expected value comes from a cycle-index model of the requirements.

// File: rtl/clk_en_pkg.sv
package clk_en_pkg;
  localparam int BIT_CORE = 0;
  localparam int BIT_SYS  = 1;
  localparam int BIT_PER1 = 2;
  localparam int BIT_PER2 = 3;
  localparam int BIT_ASY1 = 4;
  localparam int BIT_ASY2 = 5;
  localparam int BIT_PER3 = 8;
  localparam int BIT_ASY3 = 10;
  localparam int CORE_LAG = 2;
  localparam int NUM_ASY  = 3;

  function automatic int asy_bit(int idx);
    case (idx)
      0:       return BIT_ASY1;
      1:       return BIT_ASY2;
      default: return BIT_ASY3;
    endcase
  endfunction
endpackage

// File: rtl/clk_en_div.sv
module clk_en_div #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] ratio_i,
  input  logic         gate_i,
  output logic         tc_o,
  output logic         en_o
);
  logic [W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic         off_q, off_d, at_end;

  always_comb begin
    at_end = (cnt_q == lim_q);
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    off_d  = off_q;
    if (at_end) begin
      cnt_d = '0;
      lim_d = ratio_i;
      off_d = gate_i;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
      off_q <= 1'b0;
    end else if (run_i) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      off_q <= off_d;
    end
  end

  assign tc_o = run_i & at_end;
  assign en_o = tc_o & ~off_q;

  // R2: counter never passes the latched limit
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);
  // R2: a nonzero ratio leaves a gap after each terminal count
  a_r2_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && ratio_i != '0) |=> !tc_o);
  // R3: the disable sampled at terminal count holds for the next period
  a_r3_gate_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && gate_i) |=> !en_o);
endmodule

// File: rtl/clk_en_tap.sv
module clk_en_tap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic gate_i,
  output logic en_o
);
  logic off_q, off_d;

  always_comb off_d = src_i ? gate_i : off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_q <= 1'b0;
    else         off_q <= off_d;
  end

  assign en_o = src_i & ~off_q;

  // R7: a disable seen on a source tick suppresses the following tick
  a_r7_tap_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i && gate_i) |=> !en_o);
endmodule

// File: rtl/clk_en_guard.sv
module clk_en_guard #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] prim_i,
  input  logic [W-1:0] sec_i,
  output logic [W-1:0] sec_eff_o,
  output logic         err_o
);
  logic [W:0] n_prim, n_sec, rem;
  logic       bad, err_q, err_d;

  always_comb begin
    n_prim    = {1'b0, prim_i} + 1'b1;
    n_sec     = {1'b0, sec_i} + 1'b1;
    rem       = n_prim % n_sec;
    bad       = (rem != '0);
    sec_eff_o = bad ? prim_i : sec_i;
    err_d     = err_q | bad;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

  // R8: error flag is sticky until reset
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R8: a violating pair raises the flag on the next edge
  a_r8_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((({1'b0, prim_i} + 1'b1) % ({1'b0, sec_i} + 1'b1)) != '0) |=> err_o));
endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
  import clk_en_pkg::*;
#(
  parameter int DIV_W  = 4,
  parameter int TEST_W = 3,
  parameter int MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MASK_W-1:0] dis_mask_i,
  input  logic [DIV_W-1:0]  per1_div_i,
  input  logic [DIV_W-1:0]  per2_div_i,
  input  logic [DIV_W-1:0]  per3_div_i,
  input  logic              selftest_i,
  input  logic [TEST_W-1:0] selftest_div_i,
  output logic              sys_en_o,
  output logic              core_en_o,
  output logic              core_lag_en_o,
  output logic              per1_en_o,
  output logic              per2_en_o,
  output logic              per3_en_o,
  output logic              asy1_en_o,
  output logic              asy2_en_o,
  output logic              asy3_en_o,
  output logic              ratio_err_o
);
  localparam logic [MASK_W-1:0] USED_BITS =
    MASK_W'((1 << BIT_CORE) | (1 << BIT_SYS) | (1 << BIT_PER1) | (1 << BIT_PER2) |
            (1 << BIT_PER3) | (1 << BIT_ASY1) | (1 << BIT_ASY2) | (1 << BIT_ASY3));

  logic                run_q;
  logic [1:0]          since_q, since_d;
  logic [CORE_LAG-1:0] lag_q, lag_d;
  logic [TEST_W-1:0]   core_ratio;
  logic [DIV_W-1:0]    per2_eff;
  logic                sys_tc, core_tc, per1_tc, per2_tc, per3_tc;
  logic [NUM_ASY-1:0]  asy_en;
  logic                unused_bits;

  always_comb begin
    core_ratio = selftest_i ? selftest_div_i : '0;
    lag_d      = {lag_q[CORE_LAG-2:0], core_en_o};
    since_d    = (since_q == 2'd3) ? since_q : since_q + 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      since_q <= 2'd0;
      lag_q   <= '0;
    end else begin
      run_q   <= 1'b1;
      since_q <= since_d;
      lag_q   <= lag_d;
    end
  end

  assign core_lag_en_o = lag_q[CORE_LAG-1];

  clk_en_div #(.W(1)) u_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ratio_i(1'b0),
    .gate_i(dis_mask_i[BIT_SYS]), .tc_o(sys_tc), .en_o(sys_en_o));

  clk_en_div #(.W(TEST_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ratio_i(core_ratio),
    .gate_i(dis_mask_i[BIT_CORE]), .tc_o(core_tc), .en_o(core_en_o));

  clk_en_div #(.W(DIV_W)) u_per1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ratio_i(per1_div_i),
    .gate_i(dis_mask_i[BIT_PER1]), .tc_o(per1_tc), .en_o(per1_en_o));

  clk_en_div #(.W(DIV_W)) u_per2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ratio_i(per2_eff),
    .gate_i(dis_mask_i[BIT_PER2]), .tc_o(per2_tc), .en_o(per2_en_o));

  clk_en_div #(.W(DIV_W)) u_per3 (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .ratio_i(per3_div_i),
    .gate_i(dis_mask_i[BIT_PER3]), .tc_o(per3_tc), .en_o(per3_en_o));

  clk_en_guard #(.W(DIV_W)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .prim_i(per1_div_i), .sec_i(per2_div_i),
    .sec_eff_o(per2_eff), .err_o(ratio_err_o));

  for (genvar i = 0; i < NUM_ASY; i++) begin : g_asy
    localparam int BITPOS = asy_bit(i);
    clk_en_tap u_tap (
      .clk_i(clk_i), .rst_ni(rst_ni), .src_i(per1_tc),
      .gate_i(dis_mask_i[BITPOS]), .en_o(asy_en[i]));
  end

  assign asy1_en_o = asy_en[0];
  assign asy2_en_o = asy_en[1];
  assign asy3_en_o = asy_en[2];

  assign unused_bits = ^(dis_mask_i & ~USED_BITS) ^ sys_tc ^ core_tc ^ per2_tc ^ per3_tc;

  // R5: lagging core strobe is the core strobe two cycles late
  a_r5_core_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q >= 2'd2) |-> (core_lag_en_o == $past(core_en_o, 2)));
  // R9: system strobe every cycle while its bit stays clear
  a_r9_sys_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !dis_mask_i[BIT_SYS]) |=> sys_en_o);
  // R4: per-domain disable bits
  a_r4_core_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_tc && dis_mask_i[BIT_CORE]) |=> !core_en_o);
  a_r4_per2_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per2_tc && dis_mask_i[BIT_PER2]) |=> !per2_en_o);
  a_r4_per3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per3_tc && dis_mask_i[BIT_PER3]) |=> !per3_en_o);
  // R7: auxiliary strobes only on primary terminal counts
  a_r7_asy_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asy1_en_o || asy2_en_o || asy3_en_o) |-> per1_tc);
endmodule

// File: tb/clk_en_gen_test.sv
module clk_en_gen_test;
  typedef struct packed {
    logic [3:0]  p1;
    logic [3:0]  p2;
    logic [3:0]  p3;
    logic        tm;
    logic [2:0]  td;
    logic [15:0] mask;
    logic        err;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0,  4'd0,  4'd0,  1'b0, 3'd0, 16'h0000, 1'b0},
    '{4'd3,  4'd1,  4'd15, 1'b0, 3'd0, 16'h0000, 1'b0},
    '{4'd5,  4'd2,  4'd6,  1'b1, 3'd2, 16'h0001, 1'b0},
    '{4'd3,  4'd2,  4'd0,  1'b1, 3'd7, 16'h0402, 1'b1},
    '{4'd7,  4'd3,  4'd4,  1'b0, 3'd0, 16'h013C, 1'b0},
    '{4'd15, 4'd15, 4'd1,  1'b1, 3'd3, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] dis_mask;
  logic [3:0]  p1, p2, p3;
  logic        tm;
  logic [2:0]  td;
  logic sys_en, core_en, lag_en, per1_en, per2_en, per3_en, a1_en, a2_en, a3_en, err;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_en_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .dis_mask_i(dis_mask),
    .per1_div_i(p1), .per2_div_i(p2), .per3_div_i(p3),
    .selftest_i(tm), .selftest_div_i(td),
    .sys_en_o(sys_en), .core_en_o(core_en), .core_lag_en_o(lag_en),
    .per1_en_o(per1_en), .per2_en_o(per2_en), .per3_en_o(per3_en),
    .asy1_en_o(a1_en), .asy2_en_o(a2_en), .asy3_en_o(a3_en),
    .ratio_err_o(err));

  task automatic chk(input string req, input string sig, input int t,
                     input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d actual %b expected %b", req, sig, t, act, exp);
    end
  endtask

  function automatic logic pulse(input int t, input int n, input logic off);
    return (t % n == 0) && (t == 0 || !off);
  endfunction

  task automatic start(input logic [3:0] a, input logic [3:0] b, input logic [3:0] c,
                       input logic m, input logic [2:0] d, input logic [15:0] k);
    @(negedge clk);
    rst_ni = 1'b0;
    p1 = a; p2 = b; p3 = c; tm = m; td = d; dis_mask = k;
    repeat (3) @(negedge clk);
    // R1: everything quiet in reset
    chk("R1", "reset strobes", -1,
        |{sys_en, core_en, lag_en, per1_en, per2_en, per3_en, a1_en, a2_en, a3_en}, 1'b0);
    chk("R1", "reset err", -1, err, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    dis_mask = '0; p1 = '0; p2 = '0; p3 = '0; tm = 1'b0; td = '0;

    // Table walk: R1 R2 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      vec_t cv = VECS[v];
      int n1 = int'(cv.p1) + 1;
      int n2 = cv.err ? n1 : int'(cv.p2) + 1;
      int n3 = int'(cv.p3) + 1;
      int nc = cv.tm ? int'(cv.td) + 1 : 1;
      start(cv.p1, cv.p2, cv.p3, cv.tm, cv.td, cv.mask);
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        chk("R9", "sys",  t, sys_en,  pulse(t, 1,  cv.mask[1]));
        chk("R6", "core", t, core_en, pulse(t, nc, cv.mask[0]));
        chk("R5", "lag",  t, lag_en,  (t >= 2) && pulse(t - 2, nc, cv.mask[0]));
        chk("R2", "per1", t, per1_en, pulse(t, n1, cv.mask[2]));
        chk("R4", "per2", t, per2_en, pulse(t, n2, cv.mask[3]));
        chk("R2", "per3", t, per3_en, pulse(t, n3, cv.mask[8]));
        chk("R7", "asy1", t, a1_en,   pulse(t, n1, cv.mask[4]));
        chk("R7", "asy2", t, a2_en,   pulse(t, n1, cv.mask[5]));
        chk("R7", "asy3", t, a3_en,   pulse(t, n1, cv.mask[10]));
        chk("R8", "err",  t, err,     cv.err);
      end
    end

    // R3: mid-period ratio and mask change on the primary peripheral
    start(4'd3, 4'd0, 4'd0, 1'b0, 3'd0, 16'h0000);
    for (int t = 0; t <= 14; t++) begin
      @(negedge clk);
      chk("R3", "per1", t, per1_en, (t == 0 || t == 4 || t == 8 || t == 10));
      chk("R3", "asy1", t, a1_en,
          (t == 0 || t == 4 || t == 8 || (t >= 10 && t % 2 == 0)));
      if (t == 5) p1 = 4'd1;
      if (t == 9) dis_mask = 16'h0004;
    end

    // R8: sticky error and forced ratio, then rule repaired without reset
    start(4'd3, 4'd2, 4'd0, 1'b0, 3'd0, 16'h0000);
    for (int t = 0; t <= 10; t++) begin
      @(negedge clk);
      chk("R8", "err sticky", t, err, 1'b1);
      chk("R8", "per2 forced", t, per2_en, (t == 0 || t == 4 || t == 6 || t == 8 || t == 10));
      if (t == 3) p2 = 4'd1;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule